// File: doc/BRIEF.md
# Open-Page DRAM Bank Command Sequencer

This block sits between a request source and the command bus of a small multi-bank DDR-style memory. Every request names a bank, a row and a column, plus a write flag and an auto-precharge flag. For each bank the block tracks whether a row is open and which one. From that state it sorts the request into one of three access classes, then emits the shortest legal command sequence for that class.

The three classes are page-hit, page-empty and page-miss. A page-hit needs only a column command. A page-empty needs Activate and then the column command. A page-miss needs Precharge, then Activate, then the column command. Rows stay open after an access, so later requests to the same row can skip the Activate.

One request is in flight at a time, and requests are served in arrival order. Every minimum spacing is a module parameter, enforced by down-counters. The request port holds `req_ready_o` low until the next command is legal. Read data timing is marked by a one-cycle strobe.

Top module: `dram_page_seq`

## Requirements
- R1: After reset no bank has an open row, so the first request to any bank is classed page-empty (`acc_class_o` = 01).
- R2: A request to the open row of its bank is classed 00 (hit). Its column command (Read = 3, Write = 4 on `cmd_o`) is driven in the acceptance cycle, with no Activate and no Precharge.
- R3: A request to a bank with no open row is classed 01 (empty). Activate (`cmd_o` = 1) is driven in the acceptance cycle and the column command T_RCD cycles later. With the defaults, read data is due 12 cycles after acceptance.
- R4: A request to a bank with a different row open is classed 10 (miss). Precharge (`cmd_o` = 2) is driven in the acceptance cycle, Activate T_RP cycles later, and the column command T_RCD cycles after that. With the defaults, read data is due 18 cycles after acceptance.
- R5: An access without auto-precharge leaves its row open, so the next request to that bank and row is a hit.
- R6: Two column commands are never closer than T_CCD cycles apart (default 4). Back-to-back hits are accepted exactly T_CCD cycles apart.
- R7: A column command with auto-precharge closes the bank. The next request to that bank is a page-empty, and its Activate comes no earlier than T_RTP + T_RP cycles after the column command (default 10).
- R8: A Precharge to a bank is driven no earlier than T_RTP cycles after the last column command to that bank (default 4).
- R9: `rd_valid_o` pulses exactly T_CL cycles after each Read command and never follows a Write.
- R10: At most one command per clock is driven. While a multi-step sequence is in progress `req_ready_o` stays low, so the next request is accepted at the earliest one cycle after the previous column command. The idle bus code is 0.
- R11: Banks are tracked independently: an access to one bank leaves the open rows of the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted this cycle if valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_autopre_i | input | 1 | Close the row after the column command |
| req_bank_i | input | BANK_W | Target bank |
| req_row_i | input | ROW_W | Target row |
| req_col_i | input | COL_W | Target column |
| acc_class_o | output | 2 | Class of the presented request: 00 hit, 01 empty, 10 miss |
| cmd_o | output | 3 | Command: 0 idle, 1 Activate, 2 Precharge, 3 Read, 4 Write |
| cmd_bank_o | output | BANK_W | Bank of the command |
| cmd_row_o | output | ROW_W | Row of the command |
| cmd_col_o | output | COL_W | Column of the command |
| cmd_autopre_o | output | 1 | Auto-precharge flag of a column command |
| rd_valid_o | output | 1 | Read data due this cycle |

## Verification
A wrong open-row register or valid flag shows up at once in `acc_class_o` for the next request to that bank. It then shows up as an extra or missing Activate or Precharge on `cmd_o` within the same sequence. A wrong spacing counter moves the acceptance cycle or the command cycle by a known number of clocks, so every sequence is checked against its exact command cycles relative to acceptance. Read strobe timing gives a second view of the column command cycle.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_PRE = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    CLS_HIT   = 2'd0,
    CLS_EMPTY = 2'd1,
    CLS_MISS  = 2'd2
  } cls_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACT_WAIT,
    ST_COL_WAIT
  } seq_st_e;
endpackage

// File: rtl/dram_bank_track.sv
module dram_bank_track
  import dram_seq_pkg::*;
#(
  parameter int ROW_W = 8,
  parameter int T_RP  = 6,
  parameter int T_RTP = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  cmd_e             cmd_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             ap_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             act_ok_o,
  output logic             pre_ok_o
);
  localparam int CNT_MAX = T_RTP + T_RP;
  localparam int CW      = $clog2(CNT_MAX + 1);

  logic             open_q;
  logic [ROW_W-1:0] row_q;
  logic [CW-1:0]    act_cnt_q, pre_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q    <= 1'b0;
      row_q     <= '0;
      act_cnt_q <= '0;
      pre_cnt_q <= '0;
    end else begin
      if (act_cnt_q != '0) act_cnt_q <= act_cnt_q - CW'(1);
      if (pre_cnt_q != '0) pre_cnt_q <= pre_cnt_q - CW'(1);
      if (sel_i) begin
        unique case (cmd_i)
          CMD_ACT: begin
            open_q <= 1'b1;
            row_q  <= row_i;
          end
          CMD_PRE: begin
            open_q    <= 1'b0;
            act_cnt_q <= CW'(T_RP - 1);
          end
          CMD_RD, CMD_WR: begin
            pre_cnt_q <= CW'(T_RTP - 1);
            if (ap_i) begin
              // internal precharge after T_RTP, idle after a further T_RP
              open_q    <= 1'b0;
              act_cnt_q <= CW'(T_RTP + T_RP - 1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign open_o   = open_q;
  assign row_o    = row_q;
  assign act_ok_o = (act_cnt_q == '0);
  assign pre_ok_o = (pre_cnt_q == '0);

  // R3 / R7: Activate only to a closed, recovered bank
  p_act_closed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && cmd_i == CMD_ACT) |-> (!open_q && act_cnt_q == '0));

  // R8: Precharge only to an open bank past read-to-precharge spacing
  p_pre_spacing_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && cmd_i == CMD_PRE) |-> (open_q && pre_cnt_q == '0));

  // R2: column command only to the open row
  p_col_row_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && (cmd_i == CMD_RD || cmd_i == CMD_WR)) |-> (open_q && row_q == row_i));
endmodule

// File: rtl/dram_rd_pipe.sv
module dram_rd_pipe #(
  parameter int T_CL = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_i,
  output logic rd_valid_o
);
  logic [T_CL-1:0] pipe_q;

  generate
    if (T_CL == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= rd_i;
      end
    end else begin : g_shift
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= {pipe_q[T_CL-2:0], rd_i};
      end
    end
  endgenerate

  assign rd_valid_o = pipe_q[T_CL-1];
endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
  import dram_seq_pkg::*;
#(
  parameter int NB    = 4,
  parameter int BW    = 2,
  parameter int ROW_W = 8,
  parameter int COL_W = 6,
  parameter int T_RCD = 6,
  parameter int T_RP  = 6,
  parameter int T_CCD = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_write_i,
  input  logic             req_autopre_i,
  input  logic [BW-1:0]    req_bank_i,
  input  logic [ROW_W-1:0] req_row_i,
  input  logic [COL_W-1:0] req_col_i,
  output cls_e             cls_o,
  input  logic [NB-1:0]    open_i,
  input  logic [ROW_W-1:0] open_row_i [NB],
  input  logic [NB-1:0]    act_ok_i,
  input  logic [NB-1:0]    pre_ok_i,
  output cmd_e             cmd_o,
  output logic [BW-1:0]    cmd_bank_o,
  output logic [ROW_W-1:0] cmd_row_o,
  output logic [COL_W-1:0] cmd_col_o,
  output logic             cmd_ap_o
);
  localparam int WMAX = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int WW   = $clog2(WMAX + 1);
  localparam int CCW  = $clog2(T_CCD + 1);

  seq_st_e          st_q, st_d;
  logic [WW-1:0]    wcnt_q, wcnt_d;
  logic [CCW-1:0]   ccd_q;
  logic             ccd_ok;
  logic             ld;
  logic             lat_we, lat_ap;
  logic [BW-1:0]    lat_bank;
  logic [ROW_W-1:0] lat_row;
  logic [COL_W-1:0] lat_col;
  cls_e             cls_w;
  logic             col_issue;

  assign ccd_ok = (ccd_q == '0);

  always_comb begin
    if (!open_i[req_bank_i])                          cls_w = CLS_EMPTY;
    else if (open_row_i[req_bank_i] == req_row_i)     cls_w = CLS_HIT;
    else                                              cls_w = CLS_MISS;
  end
  assign cls_o = cls_w;

  always_comb begin
    st_d        = st_q;
    wcnt_d      = (wcnt_q != '0) ? wcnt_q - WW'(1) : '0;
    ld          = 1'b0;
    req_ready_o = 1'b0;
    cmd_o       = CMD_NOP;
    cmd_bank_o  = lat_bank;
    cmd_row_o   = lat_row;
    cmd_col_o   = lat_col;
    cmd_ap_o    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        unique case (cls_w)
          CLS_HIT:   req_ready_o = ccd_ok;
          CLS_EMPTY: req_ready_o = act_ok_i[req_bank_i];
          default:   req_ready_o = pre_ok_i[req_bank_i];
        endcase
        if (req_valid_i && req_ready_o) begin
          ld         = 1'b1;
          cmd_bank_o = req_bank_i;
          cmd_row_o  = req_row_i;
          cmd_col_o  = req_col_i;
          unique case (cls_w)
            CLS_HIT: begin
              cmd_o    = req_write_i ? CMD_WR : CMD_RD;
              cmd_ap_o = req_autopre_i;
            end
            CLS_EMPTY: begin
              cmd_o  = CMD_ACT;
              st_d   = ST_COL_WAIT;
              wcnt_d = WW'(T_RCD - 1);
            end
            default: begin
              cmd_o  = CMD_PRE;
              st_d   = ST_ACT_WAIT;
              wcnt_d = WW'(T_RP - 1);
            end
          endcase
        end
      end
      ST_ACT_WAIT: begin
        if (wcnt_q == '0 && act_ok_i[lat_bank]) begin
          cmd_o  = CMD_ACT;
          st_d   = ST_COL_WAIT;
          wcnt_d = WW'(T_RCD - 1);
        end
      end
      ST_COL_WAIT: begin
        if (wcnt_q == '0 && ccd_ok) begin
          cmd_o    = lat_we ? CMD_WR : CMD_RD;
          cmd_ap_o = lat_ap;
          st_d     = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign col_issue = (cmd_o == CMD_RD) || (cmd_o == CMD_WR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      wcnt_q   <= '0;
      ccd_q    <= '0;
      lat_we   <= 1'b0;
      lat_ap   <= 1'b0;
      lat_bank <= '0;
      lat_row  <= '0;
      lat_col  <= '0;
    end else begin
      st_q   <= st_d;
      wcnt_q <= wcnt_d;
      if (col_issue)          ccd_q <= CCW'(T_CCD - 1);
      else if (ccd_q != '0)   ccd_q <= ccd_q - CCW'(1);
      if (ld) begin
        lat_we   <= req_write_i;
        lat_ap   <= req_autopre_i;
        lat_bank <= req_bank_i;
        lat_row  <= req_row_i;
        lat_col  <= req_col_i;
      end
    end
  end

  // R10: a sequence in progress never reports acceptance of a new request
  p_busy_holds_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_PRE) |=> !req_ready_o);
endmodule

// File: rtl/dram_page_seq.sv
module dram_page_seq
  import dram_seq_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 8,
  parameter int COL_W  = 6,
  parameter int T_CL   = 6,
  parameter int T_RCD  = 6,
  parameter int T_RP   = 6,
  parameter int T_RTP  = 4,
  parameter int T_CCD  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic              req_autopre_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  output logic [1:0]        acc_class_o,
  output logic [2:0]        cmd_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ROW_W-1:0]  cmd_row_o,
  output logic [COL_W-1:0]  cmd_col_o,
  output logic              cmd_autopre_o,
  output logic              rd_valid_o
);
  localparam int NB  = 1 << BANK_W;
  localparam int GW  = $clog2(T_CCD + 1);
  localparam int OW  = $clog2(T_CL + 2);

  cmd_e             cmd_w;
  cls_e             cls_w;
  logic [NB-1:0]    open_w, act_ok_w, pre_ok_w;
  logic [ROW_W-1:0] open_row_w [NB];

  dram_seq_ctrl #(
    .NB(NB), .BW(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .T_RCD(T_RCD), .T_RP(T_RP), .T_CCD(T_CCD)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .req_write_i  (req_write_i),
    .req_autopre_i(req_autopre_i),
    .req_bank_i   (req_bank_i),
    .req_row_i    (req_row_i),
    .req_col_i    (req_col_i),
    .cls_o        (cls_w),
    .open_i       (open_w),
    .open_row_i   (open_row_w),
    .act_ok_i     (act_ok_w),
    .pre_ok_i     (pre_ok_w),
    .cmd_o        (cmd_w),
    .cmd_bank_o   (cmd_bank_o),
    .cmd_row_o    (cmd_row_o),
    .cmd_col_o    (cmd_col_o),
    .cmd_ap_o     (cmd_autopre_o)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    dram_bank_track #(
      .ROW_W(ROW_W), .T_RP(T_RP), .T_RTP(T_RTP)
    ) u_track (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sel_i   (cmd_bank_o == BANK_W'(b)),
      .cmd_i   (cmd_w),
      .row_i   (cmd_row_o),
      .ap_i    (cmd_autopre_o),
      .open_o  (open_w[b]),
      .row_o   (open_row_w[b]),
      .act_ok_o(act_ok_w[b]),
      .pre_ok_o(pre_ok_w[b])
    );
  end

  dram_rd_pipe #(.T_CL(T_CL)) u_rd_pipe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_i      (cmd_w == CMD_RD),
    .rd_valid_o(rd_valid_o)
  );

  assign cmd_o       = cmd_w;
  assign acc_class_o = cls_w;

  // checker state: cycles since last column command, reads outstanding
  logic          col_w;
  logic [GW-1:0] col_gap_q;
  logic [OW-1:0] rd_out_q;

  assign col_w = (cmd_w == CMD_RD) || (cmd_w == CMD_WR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_gap_q <= GW'(T_CCD);
      rd_out_q  <= '0;
    end else begin
      if (col_w)                         col_gap_q <= GW'(1);
      else if (col_gap_q < GW'(T_CCD))   col_gap_q <= col_gap_q + GW'(1);
      if ((cmd_w == CMD_RD) && !rd_valid_o)      rd_out_q <= rd_out_q + OW'(1);
      else if ((cmd_w != CMD_RD) && rd_valid_o)  rd_out_q <= rd_out_q - OW'(1);
    end
  end

  // R6: column commands spaced by at least T_CCD
  p_ccd_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_w |-> (col_gap_q >= GW'(T_CCD)));

  // R9: a data strobe always has an issued Read behind it
  p_rd_due_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (rd_out_q != '0));
endmodule

// File: tb/dram_page_seq_test.sv
module dram_page_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0, req_ap = 1'b0;
  logic [1:0] req_bank = '0;
  logic [7:0] req_row = '0;
  logic [5:0] req_col = '0;
  logic       req_ready, cmd_ap, rd_valid;
  logic [1:0] acc_class, cmd_bank;
  logic [2:0] cmd;
  logic [7:0] cmd_row;
  logic [5:0] cmd_col;

  always #5 clk = ~clk;

  dram_page_seq uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_autopre_i(req_ap),
    .req_bank_i(req_bank), .req_row_i(req_row), .req_col_i(req_col),
    .acc_class_o(acc_class), .cmd_o(cmd), .cmd_bank_o(cmd_bank),
    .cmd_row_o(cmd_row), .cmd_col_o(cmd_col), .cmd_autopre_o(cmd_ap),
    .rd_valid_o(rd_valid)
  );

  int total = 0, bad = 0, cyc = 0;
  int last_pre = -100, last_act = -100, last_col = -100, last_rdv = -100;
  int acc = -100, prev_acc = -100, acc_cls = -1;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd == 3'd2) last_pre = cyc;
      if (cmd == 3'd1) last_act = cyc;
      if (cmd == 3'd3 || cmd == 3'd4) last_col = cyc;
      if (rd_valid) last_rdv = cyc;
      if (req_valid && req_ready) begin
        prev_acc = acc;
        acc      = cyc;
        acc_cls  = int'(acc_class);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc == 50000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<50000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input int actual, input int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic issue(input int bank, input int row, input bit we, input bit ap);
    @(posedge clk); #1;
    req_valid = 1'b1; req_bank = 2'(bank); req_row = 8'(row);
    req_col = 6'(row + 1); req_write = we; req_ap = ap;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk); #1;
  endtask

  // {we, ap, bank[1:0], row[7:0], class[1:0]}
  localparam logic [13:0] VEC [12] = '{
    {1'b0, 1'b0, 2'd0, 8'd5, 2'd1},   // R1 R3 first touch
    {1'b0, 1'b0, 2'd0, 8'd5, 2'd0},   // R2 R5 hit
    {1'b0, 1'b0, 2'd0, 8'd9, 2'd2},   // R4 miss
    {1'b1, 1'b0, 2'd1, 8'd3, 2'd1},   // R9 write, no strobe
    {1'b1, 1'b0, 2'd0, 8'd9, 2'd0},   // R11 bank0 kept
    {1'b0, 1'b0, 2'd1, 8'd3, 2'd0},
    {1'b0, 1'b1, 2'd2, 8'd7, 2'd1},   // R7 closes
    {1'b0, 1'b0, 2'd2, 8'd7, 2'd1},
    {1'b1, 1'b0, 2'd1, 8'd4, 2'd2},
    {1'b0, 1'b0, 2'd3, 8'd1, 2'd1},
    {1'b0, 1'b1, 2'd0, 8'd9, 2'd0},
    {1'b0, 1'b0, 2'd0, 8'd9, 2'd1}
  };

  initial begin
    int c1, a1;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 idle bus in reset", int'(cmd), 0);
    chk("R9 no strobe in reset", int'(rd_valid), 0);
    rst_n = 1'b1;
    req_bank = 2'd2; req_row = 8'd33;
    @(negedge clk);
    chk("R1 reset class empty", int'(acc_class), 1);

    for (int i = 0; i < 12; i++) begin
      logic [13:0] v;
      int ecls;
      v = VEC[i];
      ecls = int'(v[1:0]);
      issue(int'(v[11:10]), int'(v[9:2]), v[13], v[12]);
      idle(22);
      chk($sformatf("R2/R3/R4 class vec%0d", i), acc_cls, ecls);
      if (ecls == 0) begin
        chk($sformatf("R2 col at accept vec%0d", i), last_col - acc, 0);
        chk($sformatf("R2 no act vec%0d", i), int'(last_act < acc), 1);
        chk($sformatf("R2 no pre vec%0d", i), int'(last_pre < acc), 1);
      end else if (ecls == 1) begin
        chk($sformatf("R3 act at accept vec%0d", i), last_act - acc, 0);
        chk($sformatf("R3 col after trcd vec%0d", i), last_col - acc, 6);
        chk($sformatf("R3 no pre vec%0d", i), int'(last_pre < acc), 1);
      end else begin
        chk($sformatf("R4 pre at accept vec%0d", i), last_pre - acc, 0);
        chk($sformatf("R4 act after trp vec%0d", i), last_act - acc, 6);
        chk($sformatf("R4 col after trcd vec%0d", i), last_col - acc, 12);
      end
      if (!v[13]) chk($sformatf("R9 strobe at cl vec%0d", i), last_rdv - last_col, 6);
      else        chk($sformatf("R9 no strobe on write vec%0d", i), int'(last_rdv < acc), 1);
    end

    // R6: two hits on bank0 row9 held back to back
    @(posedge clk); #1;
    req_valid = 1'b1; req_bank = 2'd0; req_row = 8'd9; req_write = 1'b0; req_ap = 1'b0;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
    idle(12);
    chk("R6 b2b accept spacing", acc - prev_acc, 4);
    chk("R6 b2b class hit", acc_cls, 0);
    chk("R6 second strobe", last_rdv - acc, 6);

    // R8: read hit then miss on bank3
    issue(3, 1, 1'b0, 1'b0);
    c1 = last_col;
    issue(3, 2, 1'b0, 1'b0);
    idle(22);
    chk("R8 class miss", acc_cls, 2);
    chk("R8 pre after trtp", last_pre - c1, 4);

    // R7: auto-precharge hit then reopen bank2
    issue(2, 7, 1'b0, 1'b1);
    c1 = last_col;
    chk("R7 ap hit class", acc_cls, 0);
    issue(2, 7, 1'b0, 1'b0);
    idle(22);
    chk("R7 reopen class empty", acc_cls, 1);
    chk("R7 act after trtp+trp", last_act - c1, 10);

    // R10: second request waits for first sequence
    issue(1, 6, 1'b0, 1'b0);
    a1 = acc;
    chk("R10 first class miss", acc_cls, 2);
    issue(2, 8, 1'b0, 1'b0);
    idle(22);
    chk("R10 second accept after col", acc - a1, 13);
    chk("R10 second class miss", acc_cls, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule